// File: doc/BRIEF.md
# CRC Error Event Counter Bank

This block is a byte-wide register bank that counts CRC failures seen by a serial link. It has two error inputs. One carries single-cycle pulses for link-layer CRC failures. The other carries pulses for end-to-end CRC failures. Each input feeds its own saturating counter. Software reaches the counters through a small memory-mapped window: a global check-enable bit, a control byte with a clear field and an enable field, a lane selector, an event code and a group code. The group and event codes pick which counter the four count bytes show.

The window's base address depends on the port width, chosen by a parameter: 0x340 for the 16-lane port, 0x308 for the 8-lane port and 0x2B4 for the 4-lane ports. The check-enable bit always sits at 0x119. Reads are registered and come back with a valid strobe one cycle after the request.

Top module: `crc_evt_cnt_bank`

## Requirements
- R1: Bit 0 of the byte at address 0x119 is the global check enable and reads back as written, with the other bits reading 0. No error pulse is counted while this bit is 0.
- R2: The window base is 0x340 when PORT_CFG=0, 0x308 when PORT_CFG=1 and 0x2B4 when PORT_CFG=2. The registers sit at these offsets from the base: +0 control, +1 lane select, +2 event code, +3 group code, +4 to +7 the selected count with the least significant byte at +4. Addresses of another port's window are unmapped.
- R3: Control bits [4:2] are the counter enable. Pulses are counted only when this field is 3'b111, so the normal control value is 0x1C.
- R4: Pulses are counted only while the lane select register is 0x00. Any other lane value stops all counting.
- R5: Group 0x02 with event 0x01 shows the link CRC counter. Group 0x03 with event 0x02 shows the end-to-end CRC counter. Any other pair makes the count bytes read 0x00. Both counters count no matter which one is selected.
- R6: A write to control bits [1:0] acts as follows: 2'b01 clears only the selected counter, 2'b11 clears both counters, and 2'b00 or 2'b10 clears nothing. The clear field does not hold its value and always reads back 2'b00.
- R7: Each counter is CNT_W bits wide and stops at all ones instead of wrapping.
- R8: A read request at address A returns the byte of A with read-valid high in the next cycle. Read-valid is low in every cycle that does not follow a request, and read data is 0x00 whenever read-valid is low. An unmapped address reads as 0x00.
- R9: When a clear and an error pulse for the same counter fall in the same cycle, the counter ends at 0.
- R10: After reset every register and both counters are 0, and read-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 21 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| link_crc_err | input | 1 | Link-layer CRC error pulse |
| e2e_crc_err | input | 1 | End-to-end CRC error pulse |

## Verification
A write takes effect at the clock edge that samples it. An error pulse raises the counter at the edge where the pulse is high. A read shows the byte at the edge after the request. The bench drives all inputs on the falling edge, so each action lands at exactly one rising edge. It samples read data on the following falling edge, when read-valid is due. Every count check is a read issued after the stimulus has been taken away. Because of this, the registered read path adds a fixed one-cycle offset and never a race with the counter update.

// File: rtl/crc_evt_pkg.sv
package crc_evt_pkg;

    localparam int unsigned ADDR_W = 21;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_LINK = 0;
    localparam int unsigned CH_E2E  = 1;

    localparam logic [ADDR_W-1:0] CHK_ADDR = 21'h00119;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_LANE  = 3'd1;
    localparam logic [2:0] OFS_EVT   = 3'd2;
    localparam logic [2:0] OFS_GRP   = 3'd3;

    localparam logic [7:0] GRP_LINK = 8'h02;
    localparam logic [7:0] EVT_LINK = 8'h01;
    localparam logic [7:0] GRP_E2E  = 8'h03;
    localparam logic [7:0] EVT_E2E  = 8'h02;

    localparam logic [1:0] CLR_ONE = 2'b01;
    localparam logic [1:0] CLR_ALL = 2'b11;

    function automatic logic [ADDR_W-1:0] port_base(input int cfg);
        case (cfg)
            1:       return 21'h00308;
            2:       return 21'h002B4;
            default: return 21'h00340;
        endcase
    endfunction

    typedef struct packed {
        logic              chk_en;
        logic [2:0]        cnt_en;
        logic [7:0]        lane;
        logic [7:0]        evt;
        logic [7:0]        grp;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } regif_state_t;

endpackage

// File: rtl/crc_evt_counter.sv
module crc_evt_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/crc_evt_regif.sv
module crc_evt_regif
    import crc_evt_pkg::*;
#(
    parameter int PORT_CFG = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [31:0]       link_word,
    input  logic [31:0]       e2e_word,
    output logic              count_ok,
    output logic [NUM_CH-1:0] clr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam logic [ADDR_W-1:0] BASE = port_base(PORT_CFG);

    regif_state_t s_d, s_q;

    logic [ADDR_W-1:0] off;
    logic              in_win;
    logic              sel_link, sel_e2e;
    logic [31:0]       sel_word;
    logic              wr_ctrl;

    always_comb begin
        off      = addr - BASE;
        in_win   = (addr >= BASE) && (off < 21'd8);
        sel_link = (s_q.grp == GRP_LINK) && (s_q.evt == EVT_LINK);
        sel_e2e  = (s_q.grp == GRP_E2E)  && (s_q.evt == EVT_E2E);
        sel_word = sel_link ? link_word : (sel_e2e ? e2e_word : 32'h0);
        wr_ctrl  = wr && in_win && (off[2:0] == OFS_CTRL);

        clr[CH_LINK] = wr_ctrl && ((wdata[1:0] == CLR_ALL) ||
                                   ((wdata[1:0] == CLR_ONE) && sel_link));
        clr[CH_E2E]  = wr_ctrl && ((wdata[1:0] == CLR_ALL) ||
                                   ((wdata[1:0] == CLR_ONE) && sel_e2e));

        count_ok = s_q.chk_en && (s_q.cnt_en == 3'b111) && (s_q.lane == 8'h00);

        s_d        = s_q;
        s_d.rvalid = rd;
        s_d.rdata  = '0;

        if (rd) begin
            if (addr == CHK_ADDR) begin
                s_d.rdata = {7'b0, s_q.chk_en};
            end else if (in_win) begin
                case (off[2:0])
                    OFS_CTRL: s_d.rdata = {3'b000, s_q.cnt_en, 2'b00};
                    OFS_LANE: s_d.rdata = s_q.lane;
                    OFS_EVT:  s_d.rdata = s_q.evt;
                    OFS_GRP:  s_d.rdata = s_q.grp;
                    3'd4:     s_d.rdata = sel_word[7:0];
                    3'd5:     s_d.rdata = sel_word[15:8];
                    3'd6:     s_d.rdata = sel_word[23:16];
                    default:  s_d.rdata = sel_word[31:24];
                endcase
            end
        end

        if (wr) begin
            if (addr == CHK_ADDR) begin
                s_d.chk_en = wdata[0];
            end else if (in_win) begin
                case (off[2:0])
                    OFS_CTRL: s_d.cnt_en = wdata[4:2];
                    OFS_LANE: s_d.lane   = wdata;
                    OFS_EVT:  s_d.evt    = wdata;
                    OFS_GRP:  s_d.grp    = wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata  = s_q.rdata;
    assign rvalid = s_q.rvalid;
endmodule

// File: rtl/crc_evt_cnt_bank.sv
module crc_evt_cnt_bank
    import crc_evt_pkg::*;
#(
    parameter int          PORT_CFG = 0,
    parameter int unsigned CNT_W    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [20:0] reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        reg_rvalid,
    input  logic        link_crc_err,
    input  logic        e2e_crc_err
);
    logic                          count_ok;
    logic [NUM_CH-1:0]             ch_clr;
    logic [NUM_CH-1:0]             ch_evt;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
    logic [NUM_CH-1:0][31:0]       ch_word;

    assign ch_evt[CH_LINK] = link_crc_err;
    assign ch_evt[CH_E2E]  = e2e_crc_err;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        crc_evt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (ch_clr[i]),
            .inc   (ch_evt[i] && count_ok),
            .cnt   (ch_cnt[i])
        );

        always_comb begin
            ch_word[i]            = '0;
            ch_word[i][CNT_W-1:0] = ch_cnt[i];
        end
    end

    crc_evt_regif #(.PORT_CFG(PORT_CFG)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .wdata     (reg_wdata),
        .link_word (ch_word[CH_LINK]),
        .e2e_word  (ch_word[CH_E2E]),
        .count_ok  (count_ok),
        .clr       (ch_clr),
        .rdata     (reg_rdata),
        .rvalid    (reg_rvalid)
    );
endmodule

// File: rtl/crc_evt_cnt_bank_chk.sv
module crc_evt_cnt_bank_chk #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_CH = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rd,
    input logic                         rvalid,
    input logic [7:0]                   rdata,
    input logic                         count_ok,
    input logic [NUM_CH-1:0]            clr,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R8
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    // R8
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);
    // R8
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> rdata == 8'h00);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R9
        clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> cnt[i] == '0);
        // R1 R3 R4
        gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!count_ok && !clr[i]) |=> $stable(cnt[i]));
        // R7
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[i] == CNT_MAX && !clr[i]) |=> cnt[i] == CNT_MAX);
        // R7
        single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr[i] |=> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + 1'b1));
    end
endmodule

bind crc_evt_cnt_bank crc_evt_cnt_bank_chk #(.CNT_W(CNT_W), .NUM_CH(2)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (reg_rd),
    .rvalid   (reg_rvalid),
    .rdata    (reg_rdata),
    .count_ok (count_ok),
    .clr      (ch_clr),
    .cnt      (ch_cnt)
);

// File: tb/crc_evt_cnt_bank_test.sv
module crc_evt_cnt_bank_test;
    localparam int unsigned CW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic        link_err = 1'b0, e2e_err = 1'b0;
    logic [7:0]  rdata, rdata4;
    logic        rvalid, rvalid4;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    crc_evt_cnt_bank #(.PORT_CFG(0), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata), .reg_rvalid(rvalid),
        .link_crc_err(link_err), .e2e_crc_err(e2e_err));

    crc_evt_cnt_bank #(.PORT_CFG(2), .CNT_W(CW)) uut_x4 (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
        .reg_wdata(wdata), .reg_rdata(rdata4), .reg_rvalid(rvalid4),
        .link_crc_err(link_err), .e2e_crc_err(e2e_err));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [20:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [20:0] a, input bit x4, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk);
        check("R8 read-valid", x4 ? rvalid4 : rvalid, 1'b1);
        d = x4 ? rdata4 : rdata;
        rd = 1'b0;
    endtask

    task automatic rd_cnt(input logic [20:0] base, input bit x4, output logic [31:0] v);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] b;
            rd_reg(base + 21'(4 + k), x4, b);
            v[8*k +: 8] = b;
        end
    endtask

    task automatic pulse(input bit l, input bit e, input int n);
        @(negedge clk); link_err = l; e2e_err = e;
        repeat (n) @(negedge clk);
        link_err = 1'b0; e2e_err = 1'b0;
    endtask

    task automatic sel(input logic [7:0] g, input logic [7:0] ev);
        wr_reg(21'h343, g);
        wr_reg(21'h342, ev);
    endtask

    task automatic t_reset();
        logic [7:0] b; logic [31:0] v;
        @(negedge clk);
        check("R10 read-valid after reset", rvalid, 1'b0);
        rd_reg(21'h119, 0, b); check("R10 check enable", b, 8'h00);
        rd_reg(21'h340, 0, b); check("R10 control", b, 8'h00);
        rd_cnt(21'h340, 0, v); check("R10 count", v, 0);
    endtask

    task automatic t_setup();
        logic [7:0] b;
        wr_reg(21'h119, 8'hFF);
        rd_reg(21'h119, 0, b); check("R1 check enable readback", b, 8'h01);
        sel(8'h02, 8'h01);
        wr_reg(21'h341, 8'h00);
        wr_reg(21'h340, 8'h1C);
        rd_reg(21'h340, 0, b); check("R6 clear field reads 00", b, 8'h1C);
        rd_reg(21'h343, 0, b); check("R2 group register", b, 8'h02);
        rd_reg(21'h342, 0, b); check("R2 event register", b, 8'h01);
    endtask

    task automatic t_count();
        logic [31:0] v;
        pulse(1, 0, 5);
        rd_cnt(21'h340, 0, v); check("R5 link count", v, 5);
        pulse(0, 1, 3);
        rd_cnt(21'h340, 0, v); check("R5 link count unaffected", v, 5);
        pulse(1, 1, 2);
        rd_cnt(21'h340, 0, v); check("R5 link count both", v, 7);
        sel(8'h03, 8'h02);
        rd_cnt(21'h340, 0, v); check("R5 e2e count", v, 5);
        sel(8'h02, 8'h02);
        rd_cnt(21'h340, 0, v); check("R5 invalid pair", v, 0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        sel(8'h02, 8'h01);
        wr_reg(21'h119, 8'h00);
        pulse(1, 0, 4);
        rd_cnt(21'h340, 0, v); check("R1 disabled check", v, 7);
        wr_reg(21'h119, 8'h01);
        wr_reg(21'h340, 8'h18);
        pulse(1, 0, 4);
        rd_cnt(21'h340, 0, v); check("R3 partial enable", v, 7);
        wr_reg(21'h340, 8'h1C);
        wr_reg(21'h341, 8'h01);
        pulse(1, 0, 4);
        rd_cnt(21'h340, 0, v); check("R4 nonzero lane", v, 7);
        wr_reg(21'h341, 8'h00);
        pulse(1, 0, 1);
        rd_cnt(21'h340, 0, v); check("R3 full enable counts", v, 8);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr_reg(21'h340, 8'h1E);
        rd_cnt(21'h340, 0, v); check("R6 code 10 no clear", v, 8);
        wr_reg(21'h340, 8'h1D);
        rd_cnt(21'h340, 0, v); check("R6 clear selected", v, 0);
        sel(8'h03, 8'h02);
        rd_cnt(21'h340, 0, v); check("R6 other kept", v, 5);
        wr_reg(21'h340, 8'h1F);
        rd_cnt(21'h340, 0, v); check("R6 clear all e2e", v, 0);
        pulse(1, 0, 2);
        sel(8'h02, 8'h01);
        rd_cnt(21'h340, 0, v); check("R6 counts after clear all", v, 2);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        pulse(1, 0, 1);
        @(negedge clk); addr = 21'h340; wdata = 8'h1D; wr = 1'b1; link_err = 1'b1;
        @(negedge clk); wr = 1'b0; link_err = 1'b0;
        rd_cnt(21'h340, 0, v); check("R9 clear beats pulse", v, 0);
        pulse(1, 0, 1);
        rd_cnt(21'h340, 0, v); check("R9 counting resumes", v, 1);
    endtask

    task automatic t_sat();
        logic [31:0] v;
        pulse(1, 0, 1030);
        rd_cnt(21'h340, 0, v); check("R7 saturated", v, 32'h3FF);
        pulse(1, 0, 5);
        rd_cnt(21'h340, 0, v); check("R7 stays saturated", v, 32'h3FF);
    endtask

    task automatic t_unmapped();
        logic [7:0] b;
        rd_reg(21'h123, 0, b); check("R8 unmapped", b, 8'h00);
        rd_reg(21'h348, 0, b); check("R8 past window", b, 8'h00);
        @(negedge clk);
        check("R8 idle read-valid", rvalid, 1'b0);
        check("R8 idle read data", rdata, 8'h00);
    endtask

    task automatic t_x4();
        logic [31:0] v; logic [7:0] b;
        wr_reg(21'h2B7, 8'h03);
        wr_reg(21'h2B6, 8'h02);
        wr_reg(21'h2B5, 8'h00);
        wr_reg(21'h2B4, 8'h1F);
        pulse(0, 1, 6);
        rd_cnt(21'h2B4, 1, v); check("R2 x4 window count", v, 6);
        rd_reg(21'h2B8, 0, b); check("R2 x16 ignores x4 window", b, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setup();
        t_count();
        t_gate();
        t_clear();
        t_prio();
        t_sat();
        t_unmapped();
        t_x4();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule